// File: doc/BRIEF.md
# Recursive Quadrant Multiplier

This block forms the full unsigned product of two equal-width operands in a single combinational pass. It is meant for datapaths that need a wide product in one cycle and want the multiplier built as a regular, repeated structure instead of one flat partial-product array.

The structure is recursive. At each size the operands are split into upper and lower halves, and four half-size multipliers form the four quadrant products. Three adders of the current width merge those products. The first adder sums the two cross terms. The second adds that sum to the upper half of the low-by-low product, which is zero-extended. The third adds the high-by-high product to the upper half of the second sum, with the cross-term carry placed above it. The lowest half of the low-by-low product passes straight to the result. The recursion ends in a 2x2 cell made of four two-input AND gates and two half adders.

The operand width is a parameter. It must be a power of two and at least 2, and its default is 16.

Top module: `vcm_mult`

## Requirements
- R1: `prod_o` equals the unsigned product `opa_i * opb_i`, at full 2*WIDTH width, for every operand pair (WIDTH = 16 by default).
- R2: When either operand is zero, `prod_o` is all zeros.
- R3: All-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1. For WIDTH = 16 this is 32'hFFFE0001.
- R4: A single-bit operand 2^i times a single-bit operand 2^j gives exactly one set bit, at position i+j, for every i and j below WIDTH.
- R5: When one operand equals 1, `prod_o` is the other operand zero-extended to 2*WIDTH bits.
- R6: `prod_o[0]` equals `opa_i[0] & opb_i[0]`.
- R7: At WIDTH = 2 the block is the base cell alone. Bit 0 is a0&b0. One half adder on a1&b0 and a0&b1 gives bit 1 and a carry. A second half adder on that carry and a1&b1 gives bit 2 and bit 3. The output is correct for all 16 operand pairs.
- R8: At WIDTH = 4 and WIDTH = 8 the product is correct for every operand pair.
- R9: The product stays correct when the sum of the two cross products overflows WIDTH bits. An example is 16'hFF80 * 16'h80FF.
- R10: When both operands are below 2^(WIDTH/2), the upper WIDTH bits of `prod_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Unsigned multiplicand |
| opb_i | input | WIDTH | Unsigned multiplier |
| prod_o | output | 2*WIDTH | Unsigned product |

## Verification
The bench builds the block four times, with WIDTH = 2, 4, 8 and 16, and drives all four copies in the same cycle. The 8-bit copy is swept over every one of its 65536 operand pairs. Its low operand bits also feed the 4-bit and 2-bit copies, so those sizes are covered exhaustively as well, and every recursion level and carry path below 16 bits is reached. The 16-bit copy receives random pairs and directed patterns: zeros, all ones, every single-bit pair, unit operands, narrow operands, and pairs whose cross products overflow. These reach the top-level carry folding that an exhaustive sweep cannot cover at that width.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // Width at which the recursion stops and the base cell is used.
  localparam int VCM_LEAF_W = 2;

  // Half of a split width.
  function automatic int vcm_half(input int w);
    return w / 2;
  endfunction
endpackage

// File: rtl/vcm_ha.sv
module vcm_ha (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

// File: rtl/vcm_cell2.sv
// Base 2x2 cell: four AND terms and two half adders.
module vcm_cell2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic t_ll, t_hl, t_lh, t_hh;
  logic sum_mid, cy_mid, sum_hi, cy_hi;

  assign t_ll = a_i[0] & b_i[0];
  assign t_hl = a_i[1] & b_i[0];
  assign t_lh = a_i[0] & b_i[1];
  assign t_hh = a_i[1] & b_i[1];

  vcm_ha u_ha_mid (.x_i(t_hl),   .y_i(t_lh), .s_o(sum_mid), .c_o(cy_mid));
  vcm_ha u_ha_hi  (.x_i(cy_mid), .y_i(t_hh), .s_o(sum_hi),  .c_o(cy_hi));

  assign p_o = {cy_hi, sum_hi, sum_mid, t_ll};
endmodule

// File: rtl/vcm_rca.sv
// Ripple adder. With WITH_CARRY = 1 the result is one bit wider and
// its top bit is the carry out. With WITH_CARRY = 0 no top carry is built.
module vcm_rca #(
  parameter int W          = 8,
  parameter int WITH_CARRY = 1
) (
  input  logic [W-1:0]            x_i,
  input  logic [W-1:0]            y_i,
  output logic [W-1+WITH_CARRY:0] s_o
);
  localparam int CW = W + WITH_CARRY;

  logic [CW-1:0] cy;

  assign cy[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign s_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
      if (i < CW - 1) begin : g_cy
        assign cy[i+1] = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
      end
    end
    if (WITH_CARRY != 0) begin : g_cout
      assign s_o[W] = cy[W];
    end
  endgenerate
endmodule

// File: rtl/vcm_node.sv
// One level of the recursion: four half-size products and three W-bit adders.
module vcm_node #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int H = vcm_pkg::vcm_half(W);

  generate
    if (W == vcm_pkg::VCM_LEAF_W) begin : g_leaf
      vcm_cell2 u_cell (.a_i(a_i), .b_i(b_i), .p_o(p_o));
    end else begin : g_split
      logic [W-1:0] pp_ll, pp_hl, pp_lh, pp_hh;
      logic [W:0]   cross_sum;
      logic [W:0]   mid_sum;
      logic [W-1:0] top_sum;
      logic         fold_cy;

      vcm_node #(.W(H)) u_ll (.a_i(a_i[H-1:0]), .b_i(b_i[H-1:0]), .p_o(pp_ll));
      vcm_node #(.W(H)) u_hl (.a_i(a_i[W-1:H]), .b_i(b_i[H-1:0]), .p_o(pp_hl));
      vcm_node #(.W(H)) u_lh (.a_i(a_i[H-1:0]), .b_i(b_i[W-1:H]), .p_o(pp_lh));
      vcm_node #(.W(H)) u_hh (.a_i(a_i[W-1:H]), .b_i(b_i[W-1:H]), .p_o(pp_hh));

      // First adder: the two cross products.
      vcm_rca #(.W(W), .WITH_CARRY(1)) u_add_cross (
        .x_i(pp_hl),
        .y_i(pp_lh),
        .s_o(cross_sum)
      );

      // Second adder: cross sum plus the zero-extended upper half of low*low.
      vcm_rca #(.W(W), .WITH_CARRY(1)) u_add_mid (
        .x_i(cross_sum[W-1:0]),
        .y_i({{H{1'b0}}, pp_ll[W-1:H]}),
        .s_o(mid_sum)
      );

      // Both carries sit at the same weight and cannot both be set.
      assign fold_cy = cross_sum[W] | mid_sum[W];

      // Third adder: high*high plus the upper half of the middle sum and the carry.
      vcm_rca #(.W(W), .WITH_CARRY(0)) u_add_top (
        .x_i(pp_hh),
        .y_i({{(H-1){1'b0}}, fold_cy, mid_sum[W-1:H]}),
        .s_o(top_sum)
      );

      assign p_o = {top_sum, mid_sum[H-1:0], pp_ll[H-1:0]};
    end
  endgenerate
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   opa_i,
  input  logic [WIDTH-1:0]   opb_i,
  output logic [2*WIDTH-1:0] prod_o
);
  vcm_node #(.W(WIDTH)) u_root (
    .a_i(opa_i),
    .b_i(opb_i),
    .p_o(prod_o)
  );
endmodule

// File: rtl/vcm_mult_chk.sv
module vcm_mult_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0]   opa_i,
  input logic [WIDTH-1:0]   opb_i,
  input logic [2*WIDTH-1:0] prod_o
);
  localparam int H  = WIDTH / 2;
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] ref_prod;
  assign ref_prod = PW'(opa_i) * PW'(opb_i);

  always_comb begin
    if (!$isunknown({opa_i, opb_i, prod_o})) begin
      AST_PRODUCT_MATCH: assert (prod_o == ref_prod)
        else $error("product mismatch"); // R1
      AST_ZERO_ABSORB: assert (!((opa_i == '0) || (opb_i == '0)) || (prod_o == '0))
        else $error("zero operand gave nonzero product"); // R2
      AST_UNIT_IDENTITY: assert ((opb_i != WIDTH'(1)) || (prod_o == PW'(opa_i)))
        else $error("unit operand not identity"); // R5
      AST_LSB_AND: assert (prod_o[0] == (opa_i[0] & opb_i[0]))
        else $error("lowest product bit wrong"); // R6
      AST_NARROW_UPPER_ZERO: assert (((opa_i >> H) != '0) || ((opb_i >> H) != '0)
                                     || (prod_o[PW-1:WIDTH] == '0))
        else $error("narrow operands set upper bits"); // R10
    end
  end
endmodule

bind vcm_mult vcm_mult_chk #(.WIDTH(WIDTH)) u_vcm_chk (
  .opa_i(opa_i),
  .opb_i(opb_i),
  .prod_o(prod_o)
);

// File: tb/test_vcm_mult.sv
module test_vcm_mult;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [1:0]  a2, b2;   logic [3:0]  p2;
  logic [3:0]  a4, b4;   logic [7:0]  p4;
  logic [7:0]  a8, b8;   logic [15:0] p8;
  logic [15:0] a16, b16; logic [31:0] p16;

  vcm_mult #(.WIDTH(2))  i_vcm_mult_w2 (.opa_i(a2),  .opb_i(b2),  .prod_o(p2));
  vcm_mult #(.WIDTH(4))  i_vcm_mult_w4 (.opa_i(a4),  .opb_i(b4),  .prod_o(p4));
  vcm_mult #(.WIDTH(8))  i_vcm_mult_w8 (.opa_i(a8),  .opb_i(b8),  .prod_o(p8));
  vcm_mult #(.WIDTH(16)) i_vcm_mult    (.opa_i(a16), .opb_i(b16), .prod_o(p16));

  typedef struct {
    logic [3:0]  e2;
    logic [7:0]  e4;
    logic [15:0] e8;
    logic [31:0] e16;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Driver: applies operands on the falling edge and queues the expected products.
  task automatic drive(input logic [15:0] x16, input logic [15:0] y16,
                       input logic [7:0] x8, input logic [7:0] y8, input string tag);
    item_t it;
    @(negedge clk);
    a16 = x16; b16 = y16;
    a8  = x8;  b8  = y8;
    a4  = x8[3:0]; b4 = y8[3:0];
    a2  = x8[1:0]; b2 = y8[1:0];
    it.e16 = 32'(64'(x16) * 64'(y16));
    it.e8  = 16'(32'(x8) * 32'(y8));
    it.e4  = 8'(16'(x8[3:0]) * 16'(y8[3:0]));
    it.e2  = 4'(8'(x8[1:0]) * 8'(y8[1:0]));
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares on the rising edge, half a period after the drive.
  always @(posedge clk) begin
    item_t it;
    if (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      check(it.tag,                  p16,          it.e16);
      check("R8 width8 exhaustive",  {16'h0, p8},  {16'h0, it.e8});
      check("R8 width4 exhaustive",  {24'h0, p4},  {24'h0, it.e4});
      check("R7 width2 base cell",   {28'h0, p2},  {28'h0, it.e2});
    end
  end

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired (R1 run incomplete)");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) drive(16'h0, 16'h0, 8'h0, 8'h0, "R2 reset-state zero operands");
    rst_n = 1'b1;

    // Exhaustive sweep of the narrow copies; random pairs on the wide copy.
    for (int i = 0; i < 65536; i++) begin
      drive(16'($urandom), 16'($urandom), i[7:0], i[15:8], "R1 random pair");
    end

    drive(16'h0000, 16'h1234, 8'h00, 8'h5A, "R2 zero multiplicand");
    drive(16'hBEEF, 16'h0000, 8'hC3, 8'h00, "R2 zero multiplier");
    drive(16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, "R3 all ones");

    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        drive(16'(1) << i, 16'(1) << j, 8'(1) << (i % 8), 8'(1) << (j % 8), "R4 single bits");
      end
    end

    drive(16'hA5C3, 16'h0001, 8'hA5, 8'h01, "R5 unit multiplier");
    drive(16'h0001, 16'h7FFF, 8'h01, 8'h7F, "R5 unit multiplicand");
    drive(16'h0001, 16'h0001, 8'h01, 8'h01, "R5 one by one");

    for (int k = 0; k < 64; k++) begin
      drive(16'($urandom), 16'($urandom), 8'(k), 8'(k + 1), "R6 lowest bit");
    end

    drive(16'hFF80, 16'h80FF, 8'hF8, 8'h8F, "R9 cross carry");
    drive(16'hFFFF, 16'h0FFF, 8'hFF, 8'h0F, "R9 cross carry wide");
    drive(16'hF0FF, 16'hFFF0, 8'hF0, 8'h0F, "R9 cross carry mixed");

    for (int k = 0; k < 200; k++) begin
      drive(16'($urandom % 256), 16'($urandom % 256), 8'($urandom), 8'($urandom), "R10 narrow operands");
    end
    drive(16'h00FF, 16'h00FF, 8'h0F, 8'h0F, "R10 narrow maximum");

    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule